// File: doc/BRIEF.md
# Real-mode code segment base register

This block holds the code-segment state of a processor that comes out of reset in real-address mode. It keeps a visible 16-bit selector, a hidden 32-bit base and a 16-bit instruction pointer. From these it produces the 32-bit linear address of the next instruction fetch, which is the hidden base plus the instruction pointer.

Reset does not follow the usual real-mode rule. The selector is set to F000h, but the hidden base is set to the high value FFFF0000h instead of 000F0000h. With the instruction pointer at FFF0h, the first fetch therefore comes from FFFFFFF0h, near the top of the 4 GiB space. The alias lasts only until the first selector load, which is any far jump, far call or interrupt. That load and every later one set the base to the selector times 16. The alias does not return before the next reset.

The instruction pointer advances by an instruction length or is loaded directly. The surrounding fetch logic drives these controls, together with the selector load strobe.

Top module: `rm_code_segment`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: `sel_out` = 16'hF000, `base_out` = 32'hFFFF0000, `alias_active` = 1 and `fetch_addr` = 32'hFFFFFFF0. The instruction pointer becomes 16'hFFF0.
- R2: One cycle after any edge, `fetch_addr` equals `base_out` plus the zero-extended instruction pointer, modulo 2^32.
- R3: A selector load (`sel_load` = 1) sets `sel_out` to `sel_in` and `base_out` to {12'h000, `sel_in`, 4'h0} in the next cycle, so the upper 12 base bits are zero.
- R4: `alias_active` is 1 from reset until the first selector load. It then reads 0 and stays 0 until the next reset.
- R5: With `ip_inc` = 1 and `ip_load` = 0, the instruction pointer advances by the zero-extended `ip_len`, modulo 2^16. `base_out` does not change.
- R6: `ip_load` = 1 sets the instruction pointer to `ip_in`. It takes priority over `ip_inc` in the same cycle.
- R7: A selector load and an instruction-pointer load in the same cycle both take effect. The next `fetch_addr` uses the new base and the new pointer.
- R8: Without a selector load, `sel_out` and `base_out` keep their values. This includes the aliased reset base.
- R9: Loading 16'hF000 after reset gives `base_out` = 32'h000F0000, not the aliased value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sel_load | input | 1 | Load a new selector (far jump, far call, interrupt) |
| sel_in | input | 16 | New selector value |
| ip_inc | input | 1 | Advance the instruction pointer by `ip_len` |
| ip_len | input | 4 | Instruction length in bytes |
| ip_load | input | 1 | Load the instruction pointer from `ip_in` |
| ip_in | input | 16 | New instruction pointer value |
| fetch_addr | output | 32 | Linear fetch address, base plus pointer |
| sel_out | output | 16 | Visible selector |
| base_out | output | 32 | Hidden base |
| alias_active | output | 1 | The post-reset high base is still in force |

## Verification
Some properties are checked by assertions on every cycle:
- the fetch address always equals the base plus the pointer;
- a cleared alias flag never sets again;
- every normal base has zero upper bits and matches the loaded selector;
- the selector and base hold without a load;
- an increment alone adds the length modulo 2^16.

Other behaviour needs the bench's scenarios:
- the exact reset values;
- the wrap of the pointer through FFFFh while the high alias is in force;
- the priority of a pointer load over an increment;
- the change from the aliased base to 000F0000h on a reload of F000h.

A sweep over all 65536 selectors, each loaded together with a pointer load, checks the base rule and the combined update.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int SEL_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int IP_W    = 16;
  localparam int LEN_W   = 4;
  localparam int SHIFT   = 4;
  localparam logic [SEL_W-1:0]  RST_SEL  = 16'hF000;
  localparam logic [ADDR_W-1:0] RST_BASE = 32'hFFFF0000;
  localparam logic [IP_W-1:0]   RST_IP   = 16'hFFF0;
endpackage

// File: rtl/cs_selector_unit.sv
module cs_selector_unit #(
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 4,
  parameter logic [SEL_W-1:0]  RST_SEL  = '0,
  parameter logic [ADDR_W-1:0] RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_load,
  input  logic [SEL_W-1:0]  sel_in,
  output logic [SEL_W-1:0]  sel_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] base_d,
  output logic              alias_q
);
  localparam int PAD = ADDR_W - SEL_W - SHIFT;

  logic [ADDR_W-1:0] norm_base;

  generate
    if (PAD > 0) begin : g_pad
      assign norm_base = {{PAD{1'b0}}, sel_in, {SHIFT{1'b0}}};
    end else begin : g_nopad
      logic [SEL_W+SHIFT-1:0] wide;
      assign wide      = {sel_in, {SHIFT{1'b0}}};
      assign norm_base = wide[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    base_d = base_q;
    if (rst)           base_d = RST_BASE;
    else if (sel_load) base_d = norm_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RST_SEL;
      base_q  <= RST_BASE;
      alias_q <= 1'b1;
    end else if (sel_load) begin
      sel_q   <= sel_in;
      base_q  <= base_d;
      alias_q <= 1'b0;
    end
  end

  AST_NORMAL_BASE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    !alias_q |-> ((base_q >> (SEL_W + SHIFT)) == '0)); // R3

  AST_LOAD_SETS_BASE: assert property (@(posedge clk) disable iff (rst)
    sel_load |=> (base_q == ({{(ADDR_W-SEL_W){1'b0}}, $past(sel_in)} << SHIFT)) && (sel_q == $past(sel_in))); // R3

  AST_ALIAS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !alias_q |=> !alias_q); // R4

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !sel_load |=> $stable(base_q) && $stable(sel_q)); // R8
endmodule

// File: rtl/cs_ip_unit.sv
module cs_ip_unit #(
  parameter int IP_W  = 16,
  parameter int LEN_W = 4,
  parameter logic [IP_W-1:0] RST_IP = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ip_inc,
  input  logic [LEN_W-1:0] ip_len,
  input  logic             ip_load,
  input  logic [IP_W-1:0]  ip_in,
  output logic [IP_W-1:0]  ip_q,
  output logic [IP_W-1:0]  ip_d
);
  logic [IP_W-1:0] len_ext;
  assign len_ext = {{(IP_W-LEN_W){1'b0}}, ip_len};

  always_comb begin
    ip_d = ip_q;
    if (rst)          ip_d = RST_IP;
    else if (ip_load) ip_d = ip_in;
    else if (ip_inc)  ip_d = ip_q + len_ext;
  end

  always_ff @(posedge clk) ip_q <= ip_d;

  AST_IP_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ip_inc && !ip_load) |=> (ip_q == $past(ip_q) + {{(IP_W-LEN_W){1'b0}}, $past(ip_len)})); // R5

  AST_IP_LOAD: assert property (@(posedge clk) disable iff (rst)
    ip_load |=> (ip_q == $past(ip_in))); // R6
endmodule

// File: rtl/cs_fetch_adder.sv
module cs_fetch_adder #(
  parameter int ADDR_W = 32,
  parameter int IP_W   = 16,
  parameter logic [ADDR_W-1:0] RST_FETCH = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_d,
  input  logic [IP_W-1:0]   ip_d,
  output logic [ADDR_W-1:0] fetch_q
);
  always_ff @(posedge clk) begin
    if (rst) fetch_q <= RST_FETCH;
    else     fetch_q <= base_d + {{(ADDR_W-IP_W){1'b0}}, ip_d};
  end
endmodule

// File: rtl/rm_code_segment.sv
module rm_code_segment
  import cs_pkg::*;
#(
  parameter int P_SEL_W  = SEL_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_IP_W   = IP_W,
  parameter int P_LEN_W  = LEN_W,
  parameter int P_SHIFT  = SHIFT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_load,
  input  logic [P_SEL_W-1:0]  sel_in,
  input  logic                ip_inc,
  input  logic [P_LEN_W-1:0]  ip_len,
  input  logic                ip_load,
  input  logic [P_IP_W-1:0]   ip_in,
  output logic [P_ADDR_W-1:0] fetch_addr,
  output logic [P_SEL_W-1:0]  sel_out,
  output logic [P_ADDR_W-1:0] base_out,
  output logic                alias_active
);
  localparam logic [P_ADDR_W-1:0] RST_FETCH =
    RST_BASE + {{(P_ADDR_W-P_IP_W){1'b0}}, RST_IP};

  logic [P_ADDR_W-1:0] base_d;
  logic [P_IP_W-1:0]   ip_q, ip_d;

  cs_selector_unit #(
    .SEL_W(P_SEL_W), .ADDR_W(P_ADDR_W), .SHIFT(P_SHIFT),
    .RST_SEL(RST_SEL), .RST_BASE(RST_BASE)
  ) u_sel (
    .clk(clk), .rst(rst), .sel_load(sel_load), .sel_in(sel_in),
    .sel_q(sel_out), .base_q(base_out), .base_d(base_d), .alias_q(alias_active)
  );

  cs_ip_unit #(
    .IP_W(P_IP_W), .LEN_W(P_LEN_W), .RST_IP(RST_IP)
  ) u_ip (
    .clk(clk), .rst(rst), .ip_inc(ip_inc), .ip_len(ip_len),
    .ip_load(ip_load), .ip_in(ip_in), .ip_q(ip_q), .ip_d(ip_d)
  );

  cs_fetch_adder #(
    .ADDR_W(P_ADDR_W), .IP_W(P_IP_W), .RST_FETCH(RST_FETCH)
  ) u_add (
    .clk(clk), .rst(rst), .base_d(base_d), .ip_d(ip_d), .fetch_q(fetch_addr)
  );

  AST_FETCH_IS_SUM: assert property (@(posedge clk) disable iff (rst)
    fetch_addr == base_out + {{(P_ADDR_W-P_IP_W){1'b0}}, ip_q}); // R2

  AST_COMBINED_LOAD: assert property (@(posedge clk) disable iff (rst)
    (sel_load && ip_load) |=> (fetch_addr == ({{(P_ADDR_W-P_SEL_W){1'b0}}, $past(sel_in)} << P_SHIFT)
                                            + {{(P_ADDR_W-P_IP_W){1'b0}}, $past(ip_in)})); // R7
endmodule

// File: tb/rm_code_segment_bench.sv
`timescale 1ns/1ps
module rm_code_segment_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel_load, ip_inc, ip_load;
  logic [15:0] sel_in, ip_in;
  logic [3:0]  ip_len;
  logic [31:0] fetch_addr, base_out;
  logic [15:0] sel_out;
  logic        alias_active;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [15:0] m_sel, m_ip;
  logic [31:0] m_base;
  logic        m_alias;

  always #2.5 clk = ~clk;

  rm_code_segment u_rm_code_segment (
    .clk(clk), .rst(rst), .sel_load(sel_load), .sel_in(sel_in),
    .ip_inc(ip_inc), .ip_len(ip_len), .ip_load(ip_load), .ip_in(ip_in),
    .fetch_addr(fetch_addr), .sel_out(sel_out), .base_out(base_out),
    .alias_active(alias_active)
  );

  task automatic check(input string tag);
    logic [31:0] exp_fetch;
    bit bad;
    exp_fetch = m_base + {16'h0000, m_ip};
    bad = 1'b0;
    vectors++;
    if (sel_out !== m_sel) begin
      $display("FAIL %s sel_out actual %h expected %h", tag, sel_out, m_sel); bad = 1'b1;
    end
    if (base_out !== m_base) begin
      $display("FAIL %s base_out actual %h expected %h", tag, base_out, m_base); bad = 1'b1;
    end
    if (alias_active !== m_alias) begin
      $display("FAIL %s alias_active actual %b expected %b", tag, alias_active, m_alias); bad = 1'b1;
    end
    if (fetch_addr !== exp_fetch) begin
      $display("FAIL %s fetch_addr actual %h expected %h", tag, fetch_addr, exp_fetch); bad = 1'b1;
    end
    if (bad) fails++;
  endtask

  task automatic step(input bit sl, input logic [15:0] s, input bit ii,
                      input logic [3:0] len, input bit il, input logic [15:0] ipv,
                      input string tag);
    @(negedge clk);
    sel_load = sl; sel_in = s; ip_inc = ii; ip_len = len; ip_load = il; ip_in = ipv;
    @(posedge clk);
    if (sl) begin
      m_sel = s; m_base = {12'h000, s, 4'h0}; m_alias = 1'b0;
    end
    if (il)      m_ip = ipv;
    else if (ii) m_ip = m_ip + {12'h000, len};
    #1 check(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel_load = 0; sel_in = 0; ip_inc = 0; ip_len = 0; ip_load = 0; ip_in = 0;
    repeat (3) @(posedge clk);
    #1;
    m_sel = 16'hF000; m_base = 32'hFFFF0000; m_ip = 16'hFFF0; m_alias = 1'b1;
    check("R1 reset state");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1 check("R1 after release");

    // Increments through the FFFFh wrap while aliased; base must not move.
    for (int i = 0; i < 400; i++)
      step(0, 16'(i * 37), 1, 4'(i % 16), 0, 16'h0, "R5 R2 R8 increment wrap");
    step(0, 16'h0, 0, 4'h0, 0, 16'h0, "R8 idle hold");

    // Pointer load, and load wins over increment.
    step(0, 16'h0, 0, 4'h0, 1, 16'h1234, "R6 ip load");
    step(0, 16'h0, 1, 4'hF, 1, 16'hABCD, "R6 load beats inc");
    step(0, 16'h0, 1, 4'h3, 0, 16'h0, "R5 inc after load");

    // First selector load with F000h ends alias and uses the normal rule.
    step(1, 16'hF000, 0, 4'h0, 1, 16'hFFF0, "R9 R4 reload F000");
    step(0, 16'h0, 1, 4'h2, 0, 16'h0, "R4 alias stays clear");

    // Full selector sweep, each with a simultaneous pointer load.
    for (int s = 0; s < 65536; s++)
      step(1, 16'(s), 1, 4'(s % 16), 1, 16'(s * 7 + 3), "R3 R7 selector sweep");

    for (int i = 0; i < 20; i++)
      step(0, 16'(i), 1, 4'hF, 0, 16'h0, "R4 R8 R5 post sweep");

    // Reset again restores the alias.
    @(negedge clk); rst = 1'b1; sel_load = 0; ip_inc = 0; ip_load = 0;
    @(posedge clk); #1;
    m_sel = 16'hF000; m_base = 32'hFFFF0000; m_ip = 16'hFFF0; m_alias = 1'b1;
    check("R1 R4 second reset");
    @(negedge clk); rst = 1'b0;
    step(1, 16'h0007, 0, 4'h0, 0, 16'h0, "R3 R4 load after second reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule